// File: doc/BRIEF.md
# Interrupt Flag and Status Register Bank

This block collects the interrupt sources of a keypad and I/O expander controller into sticky flag bits and drives one combined interrupt line towards the host. Event pulses arrive one cycle wide from the key scanner, the general-purpose input (GPI) pin logic, two logic blocks, the FIFO and the lock logic. The block latches each pulse into its flag. Software reads the flags over a simple register port and clears them by writing 1 (write-1-to-clear).

Two rules go beyond plain latching. The lock flag is raised only by lock or unlock transitions that hardware caused, and never by a change that software made through the lock-enable control. The GPI summary flag cannot be cleared while any per-pin GPI flag is still pending. GPI pins routed to the FIFO bypass the per-pin and summary flags and raise the event flag instead.

A read-only status register shows both logic-block outputs, the current lock state and the FIFO event count. An identification register sits at address 0x00.

Top module: `intstat_bank`

## Requirements
- R1: Address 0x00 reads {4'b0001, REV_CODE}, where REV_CODE defaults to 4'h2. After reset, every flag and every per-pin flag reads zero and `irq_o` is low.
- R2: Address 0x01 holds the flags: event at bit 0, GPI summary at bit 1, overflow at bit 2, lock at bit 3, logic-1 at bit 4 and logic-2 at bit 5. Bits 7:6 always read 0. A set flag stays set until software clears it.
- R3: Writing 1 to a bit of 0x01 clears that flag. Writing 0 has no effect, and neither do writes to bits 7:6.
- R4: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: The event flag (bit 0) is set by a key pulse, by a logic-block event routed to the FIFO, and by a GPI pin event on a pin whose route-to-FIFO input is 1.
- R6: A change of `lock_level_i` with `lock_sw_i` low sets the lock flag (bit 3). This holds for locking and unlocking alike. Status bit 5 then shows the new lock level.
- R7: A change of `lock_level_i` in a cycle where `lock_sw_i` is high leaves the lock flag unchanged, and status bit 5 still follows the level.
- R8: A pulse on GPI pin p with route-to-FIFO 0 sets bit p%8 of the per-pin register at address 0x03 + p/8 and sets the GPI summary flag (bit 1). With route-to-FIFO 1, it sets neither. Per-pin registers clear by writing 1, and unused upper bits read 0.
- R9: A write of 1 to GPI summary bit 1 is ignored while any per-pin flag is set. Once all per-pin flags are clear, the same write clears it.
- R10: Overflow, logic-1 and logic-2 pulses set flag bits 2, 4 and 5 respectively.
- R11: Address 0x02 reads {logic-2 output, logic-1 output, lock level, 5-bit FIFO count}, with bit 7 as the most significant bit.
- R12: `irq_o` goes high one cycle after any flag becomes set, and goes low one cycle after all flags are clear.
- R13: Addresses above the last per-pin register read 0, and writes to them change no state.
- R14: `reg_rd_data_o` is loaded at the clock edge where `reg_rd_en_i` is high, with the register contents from before that edge. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_ev_i | input | 1 | Key press or release pulse |
| gpi_pin_ev_i | input | NUM_GPI | Per-pin GPI event pulses |
| gpi_to_fifo_i | input | NUM_GPI | Per-pin route-to-FIFO selection |
| logic_fifo_ev_i | input | 1 | Logic-block event routed to the FIFO |
| logic1_ev_i | input | 1 | Logic block 1 general interrupt pulse |
| logic2_ev_i | input | 1 | Logic block 2 general interrupt pulse |
| overflow_ev_i | input | 1 | FIFO overflow pulse |
| lock_level_i | input | 1 | Current lock state, 1 = locked |
| lock_sw_i | input | 1 | High when a lock change was made by software |
| fifo_count_i | input | 5 | Events held in the FIFO |
| logic1_out_i | input | 1 | Logic block 1 output level |
| logic2_out_i | input | 1 | Logic block 2 output level |
| reg_addr_i | input | 8 | Register address |
| reg_wr_en_i | input | 1 | Write strobe |
| reg_wr_data_i | input | 8 | Write data |
| reg_rd_en_i | input | 1 | Read strobe |
| reg_rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
A source pulse presented before a clock edge sets its flag at that edge. `irq_o` follows at the next edge, so the bench samples `irq_o` once after the pulse edge, expecting it still low, and again one edge later. Register reads cost one edge and return the contents from before that edge. Each stimulus is therefore separated from the read that checks it by at least one edge. Lock status is read only after the level change has been registered.

// File: rtl/intstat_pkg.sv
// Package: shared address map, flag positions and status layout for the
// interrupt flag bank. Assumes an 8-bit register port.
package intstat_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 8;
    localparam int FLAG_W = 6;
    localparam int COUNT_W = 5;

    localparam logic [REG_AW-1:0] ADDR_ID     = 8'h00;
    localparam logic [REG_AW-1:0] ADDR_FLAGS  = 8'h01;
    localparam logic [REG_AW-1:0] ADDR_STATUS = 8'h02;
    localparam int                PIN_BASE    = 3;

    localparam int FB_EVENT = 0;
    localparam int FB_GPI   = 1;
    localparam int FB_OVF   = 2;
    localparam int FB_LOCK  = 3;
    localparam int FB_LOG1  = 4;
    localparam int FB_LOG2  = 5;

    localparam logic [3:0] MFR_CODE = 4'b0001;

    typedef struct packed {
        logic               log2_out;
        logic               log1_out;
        logic               locked;
        logic [COUNT_W-1:0] count;
    } status_t;
endpackage

// File: rtl/intstat_w1c_bank.sv
// Module: a vector of sticky flags. Set pulses win over clears; a clear
// request on a bit whose hold input is high is ignored.
// Assumes set/clear inputs are single-cycle qualified requests.
module intstat_w1c_bank #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    input  logic [WIDTH-1:0] hold_i,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] flag_q;
    logic [WIDTH-1:0] clr_eff;

    // Purpose: a clear takes effect only where it is not held off.
    always_comb clr_eff = clr_i & ~hold_i;

    // Purpose: sticky update with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= set_i | (flag_q & ~clr_eff);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/intstat_lock_watch.sv
// Module: registers the lock level and reports transitions that hardware
// caused. Assumes lock_sw_i is high in the very cycle a software-made
// level change is presented.
module intstat_lock_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_level_i,
    input  logic lock_sw_i,
    output logic level_o,
    output logic hw_toggle_o
);
    logic level_q;

    // Purpose: keep the last seen lock level.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= lock_level_i;
    end

    // Purpose: a level change not tagged as software-made is a hardware event.
    always_comb hw_toggle_o = (lock_level_i != level_q) && !lock_sw_i;

    assign level_o = level_q;
endmodule

// File: rtl/intstat_gpi_route.sv
// Module: splits GPI pin events between the per-pin general flags and the
// FIFO-reporting path. Purely combinational.
module intstat_gpi_route #(
    parameter int NUM_GPI = 19
) (
    input  logic [NUM_GPI-1:0] pin_ev_i,
    input  logic [NUM_GPI-1:0] to_fifo_i,
    output logic [NUM_GPI-1:0] pin_set_o,
    output logic               any_general_o,
    output logic               fifo_hit_o
);
    // Purpose: route each pin event by its mode and fold the results.
    always_comb begin
        pin_set_o     = pin_ev_i & ~to_fifo_i;
        any_general_o = |pin_set_o;
        fifo_hit_o    = |(pin_ev_i & to_fifo_i);
    end
endmodule

// File: rtl/intstat_reg_port.sv
// Module: address decode for clearing writes and the registered read path.
// Assumes one access per cycle; unmapped addresses read zero.
module intstat_reg_port
    import intstat_pkg::*;
#(
    parameter int         NUM_GPI  = 19,
    parameter logic [3:0] REV_CODE = 4'h2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [REG_DW-1:0]   wr_data_i,
    input  logic                rd_en_i,
    input  logic [FLAG_W-1:0]   flags_i,
    input  logic [NUM_GPI-1:0]  pins_i,
    input  status_t             status_i,
    output logic [FLAG_W-1:0]   flag_clr_o,
    output logic [NUM_GPI-1:0]  pin_clr_o,
    output logic [REG_DW-1:0]   rd_data_o
);
    localparam int NREG  = (NUM_GPI + REG_DW - 1) / REG_DW;
    localparam int PAD_W = NREG * REG_DW;

    logic [PAD_W-1:0]  pin_pad;
    logic [REG_DW-1:0] rd_mux;
    logic [REG_DW-1:0] rd_q;

    // Purpose: zero-extend the per-pin flags to whole registers.
    always_comb begin
        pin_pad              = '0;
        pin_pad[NUM_GPI-1:0] = pins_i;
    end

    // Purpose: clearing mask for the main flag register.
    always_comb flag_clr_o = (wr_en_i && addr_i == ADDR_FLAGS) ? wr_data_i[FLAG_W-1:0] : '0;

    // Per-pin clear strobes, one per pin at its fixed register and bit.
    for (genvar p = 0; p < NUM_GPI; p++) begin : g_pin_clr
        localparam int RIDX = p / REG_DW;
        localparam int BIDX = p % REG_DW;
        assign pin_clr_o[p] = wr_en_i && (addr_i == 8'(PIN_BASE + RIDX)) && wr_data_i[BIDX];
    end

    // Purpose: select the addressed register for reading.
    always_comb begin
        rd_mux = '0;
        if (addr_i == ADDR_ID)          rd_mux = {MFR_CODE, REV_CODE};
        else if (addr_i == ADDR_FLAGS)  rd_mux = {{(REG_DW-FLAG_W){1'b0}}, flags_i};
        else if (addr_i == ADDR_STATUS) rd_mux = status_i;
        else begin
            for (int r = 0; r < NREG; r++) begin
                if (addr_i == 8'(PIN_BASE + r)) rd_mux = pin_pad[r*REG_DW +: REG_DW];
            end
        end
    end

    // Purpose: capture read data on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_mux;
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/intstat_bank.sv
// Module: top of the interrupt flag bank. Latches source pulses into
// sticky flags, applies the lock and GPI clearing rules, serves the
// register port and drives the registered combined interrupt.
// Assumes all event inputs are synchronous single-cycle pulses.
module intstat_bank
    import intstat_pkg::*;
#(
    parameter int         NUM_GPI  = 19,
    parameter logic [3:0] REV_CODE = 4'h2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                key_ev_i,
    input  logic [NUM_GPI-1:0]  gpi_pin_ev_i,
    input  logic [NUM_GPI-1:0]  gpi_to_fifo_i,
    input  logic                logic_fifo_ev_i,
    input  logic                logic1_ev_i,
    input  logic                logic2_ev_i,
    input  logic                overflow_ev_i,
    input  logic                lock_level_i,
    input  logic                lock_sw_i,
    input  logic [4:0]          fifo_count_i,
    input  logic                logic1_out_i,
    input  logic                logic2_out_i,
    input  logic [7:0]          reg_addr_i,
    input  logic                reg_wr_en_i,
    input  logic [7:0]          reg_wr_data_i,
    input  logic                reg_rd_en_i,
    output logic [7:0]          reg_rd_data_o,
    output logic                irq_o
);
    logic [NUM_GPI-1:0] pin_set, pin_clr, pin_q;
    logic               any_general, fifo_hit;
    logic               lock_q, lock_hw;
    logic [FLAG_W-1:0]  flag_set, flag_clr, flag_hold, flag_q;
    status_t            status;
    logic               irq_q;

    intstat_gpi_route #(.NUM_GPI(NUM_GPI)) u_route (
        .pin_ev_i      (gpi_pin_ev_i),
        .to_fifo_i     (gpi_to_fifo_i),
        .pin_set_o     (pin_set),
        .any_general_o (any_general),
        .fifo_hit_o    (fifo_hit)
    );

    intstat_lock_watch u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_level_i (lock_level_i),
        .lock_sw_i    (lock_sw_i),
        .level_o      (lock_q),
        .hw_toggle_o  (lock_hw)
    );

    // Purpose: map each source onto its flag position and hold rule.
    always_comb begin
        flag_set           = '0;
        flag_set[FB_EVENT] = key_ev_i | fifo_hit | logic_fifo_ev_i;
        flag_set[FB_GPI]   = any_general;
        flag_set[FB_OVF]   = overflow_ev_i;
        flag_set[FB_LOCK]  = lock_hw;
        flag_set[FB_LOG1]  = logic1_ev_i;
        flag_set[FB_LOG2]  = logic2_ev_i;
        flag_hold          = '0;
        flag_hold[FB_GPI]  = |pin_q;
    end

    intstat_w1c_bank #(.WIDTH(FLAG_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .hold_i (flag_hold),
        .flag_o (flag_q)
    );

    intstat_w1c_bank #(.WIDTH(NUM_GPI)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pin_set),
        .clr_i  (pin_clr),
        .hold_i ('0),
        .flag_o (pin_q)
    );

    // Purpose: assemble the read-only status word.
    always_comb begin
        status.log2_out = logic2_out_i;
        status.log1_out = logic1_out_i;
        status.locked   = lock_q;
        status.count    = fifo_count_i;
    end

    intstat_reg_port #(.NUM_GPI(NUM_GPI), .REV_CODE(REV_CODE)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .wr_en_i    (reg_wr_en_i),
        .wr_data_i  (reg_wr_data_i),
        .rd_en_i    (reg_rd_en_i),
        .flags_i    (flag_q),
        .pins_i     (pin_q),
        .status_i   (status),
        .flag_clr_o (flag_clr),
        .pin_clr_o  (pin_clr),
        .rd_data_o  (reg_rd_data_o)
    );

    // Purpose: registered combined interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |flag_q;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/intstat_bank_checker.sv
// Module: temporal checks on the flag bank, bound into every instance.
module intstat_bank_checker
    import intstat_pkg::*;
#(
    parameter int NUM_GPI = 19
) (
    input logic               clk,
    input logic               rst_n,
    input logic [FLAG_W-1:0]  flags,
    input logic [NUM_GPI-1:0] pins,
    input logic               irq_o,
    input logic [7:0]         reg_addr_i,
    input logic               reg_wr_en_i,
    input logic               reg_rd_en_i,
    input logic [7:0]         reg_rd_data_o,
    input logic               overflow_ev_i,
    input logic               lock_sw_i
);
    localparam int LAST_ADDR = PIN_BASE + (NUM_GPI + 7) / 8 - 1;

    // R2: flags only drop when the flag register is written.
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en_i && reg_addr_i == ADDR_FLAGS) |=> ((flags & $past(flags)) == $past(flags)));

    // R2: reserved bits of the flag register read as zero.
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en_i && reg_addr_i == ADDR_FLAGS) |=> (reg_rd_data_o[7:6] == 2'b00));

    // R4: an overflow pulse leaves the overflow flag set, whatever is written.
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_ev_i |=> flags[FB_OVF]);

    // R7: a software-made lock change never raises the lock flag.
    assert_sw_lock_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[FB_LOCK] && lock_sw_i) |=> !flags[FB_LOCK]);

    // R9: the GPI summary survives while per-pin flags are pending.
    assert_gpi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FB_GPI] && (|pins)) |=> flags[FB_GPI]);

    // R12: the interrupt follows a new flag one cycle later.
    assert_irq_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|flags) |=> irq_o);

    // R12: the interrupt drops one cycle after all flags are clear.
    assert_irq_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |=> !irq_o);

    // R13: unmapped addresses read zero.
    assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en_i && int'(reg_addr_i) > LAST_ADDR) |=> (reg_rd_data_o == 8'h00));
endmodule

bind intstat_bank intstat_bank_checker #(.NUM_GPI(NUM_GPI)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flags         (flag_q),
    .pins          (pin_q),
    .irq_o         (irq_o),
    .reg_addr_i    (reg_addr_i),
    .reg_wr_en_i   (reg_wr_en_i),
    .reg_rd_en_i   (reg_rd_en_i),
    .reg_rd_data_o (reg_rd_data_o),
    .overflow_ev_i (overflow_ev_i),
    .lock_sw_i     (lock_sw_i)
);

// File: tb/intstat_bank_test.sv
// Bench: sweeps the flag sources, clear masks, GPI pins, status inputs and
// unmapped addresses; expected values come from the requirement text.
module intstat_bank_test;
    localparam int NG = 19;
    localparam int NREG = (NG + 7) / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_ev = 0, logic_fifo_ev = 0, logic1_ev = 0, logic2_ev = 0, overflow_ev = 0;
    logic [NG-1:0] gpi_ev = '0, gpi_fifo = '0;
    logic          lock_level = 0, lock_sw = 0;
    logic [4:0]    fifo_count = '0;
    logic          logic1_out = 0, logic2_out = 0;
    logic [7:0]    reg_addr = '0, reg_wr_data = '0;
    logic          reg_wr_en = 0, reg_rd_en = 0;
    logic [7:0]    reg_rd_data;
    logic          irq;
    int            checks = 0, fails = 0;
    logic [7:0]    d;

    always #5 clk = ~clk;

    intstat_bank #(.NUM_GPI(NG), .REV_CODE(4'h2)) uut (
        .clk (clk), .rst_n (rst_n), .key_ev_i (key_ev), .gpi_pin_ev_i (gpi_ev),
        .gpi_to_fifo_i (gpi_fifo), .logic_fifo_ev_i (logic_fifo_ev),
        .logic1_ev_i (logic1_ev), .logic2_ev_i (logic2_ev), .overflow_ev_i (overflow_ev),
        .lock_level_i (lock_level), .lock_sw_i (lock_sw), .fifo_count_i (fifo_count),
        .logic1_out_i (logic1_out), .logic2_out_i (logic2_out), .reg_addr_i (reg_addr),
        .reg_wr_en_i (reg_wr_en), .reg_wr_data_i (reg_wr_data), .reg_rd_en_i (reg_rd_en),
        .reg_rd_data_o (reg_rd_data), .irq_o (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd_en = 1'b1;
        @(negedge clk);
        reg_rd_en = 1'b0;
        v = reg_rd_data;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        reg_addr = a; reg_wr_data = v; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Pulse one source: 0 key, 1 GPI pin 0 routed to FIFO, 2 logic FIFO,
    // 3 overflow, 4 logic-1, 5 logic-2.
    task automatic pulse(input int s);
        case (s)
            0: key_ev = 1'b1;
            1: begin gpi_fifo[0] = 1'b1; gpi_ev[0] = 1'b1; end
            2: logic_fifo_ev = 1'b1;
            3: overflow_ev = 1'b1;
            4: logic1_ev = 1'b1;
            default: logic2_ev = 1'b1;
        endcase
        @(negedge clk);
        key_ev = 0; logic_fifo_ev = 0; overflow_ev = 0; logic1_ev = 0; logic2_ev = 0;
        gpi_ev = '0; gpi_fifo = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and identification.
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        rd(8'h00, d); check("R1 id", d, 8'h12);
        rd(8'h01, d); check("R1 flags after reset", d, 8'h00);
        for (int r = 0; r < NREG; r++) begin
            rd(8'(3 + r), d); check("R1 pin reg after reset", d, 8'h00);
        end

        // R5 R10 R12 R2 R3: each source sets its own bit, sticks, clears.
        for (int s = 0; s < 6; s++) begin
            automatic logic [7:0] bitv = (s < 3) ? 8'h01 : (s == 3) ? 8'h04 : (s == 4) ? 8'h10 : 8'h20;
            pulse(s);
            check("R12 irq not yet high", {7'd0, irq}, 8'h00);
            @(negedge clk);
            check("R12 irq high", {7'd0, irq}, 8'h01);
            rd(8'h01, d); check(s < 3 ? "R5 event source" : "R10 source bit", d, bitv);
            repeat (3) @(negedge clk);
            wr(8'h01, 8'h00);
            rd(8'h01, d); check("R2 sticky and R3 write zero", d, bitv);
            wr(8'h01, bitv);
            check("R12 irq held one cycle", {7'd0, irq}, 8'h01);
            @(negedge clk);
            check("R12 irq low", {7'd0, irq}, 8'h00);
            rd(8'h01, d); check("R3 cleared", d, 8'h00);
        end

        // R3: every clearing mask over all six flags.
        for (int m = 0; m < 64; m++) begin
            key_ev = 1; overflow_ev = 1; logic1_ev = 1; logic2_ev = 1; gpi_ev[0] = 1;
            lock_level = ~lock_level;
            @(negedge clk);
            key_ev = 0; overflow_ev = 0; logic1_ev = 0; logic2_ev = 0; gpi_ev = '0;
            wr(8'h03, 8'h01);
            wr(8'h01, 8'(m) | 8'hC0);
            rd(8'h01, d); check("R3 mask sweep", d, 8'h3F & ~8'(m));
            wr(8'h01, 8'h3F);
        end
        rd(8'h01, d); check("R2 reserved bits zero", d, 8'h00);

        // R4: set and clear in the same cycle.
        pulse(3);
        overflow_ev = 1; reg_addr = 8'h01; reg_wr_data = 8'h04; reg_wr_en = 1;
        @(negedge clk);
        overflow_ev = 0; reg_wr_en = 0;
        rd(8'h01, d); check("R4 set wins", d, 8'h04);
        wr(8'h01, 8'h04);

        // R6 R7: lock transitions (lock_level currently 0 after 64 toggles).
        lock_level = 1; @(negedge clk);
        rd(8'h01, d); check("R6 hw lock flag", d, 8'h08);
        rd(8'h02, d); check("R6 status locked", d & 8'h20, 8'h20);
        wr(8'h01, 8'h08);
        lock_level = 0; @(negedge clk);
        rd(8'h01, d); check("R6 hw unlock flag", d, 8'h08);
        rd(8'h02, d); check("R6 status unlocked", d & 8'h20, 8'h00);
        wr(8'h01, 8'h08);
        lock_level = 1; lock_sw = 1; @(negedge clk); lock_sw = 0;
        rd(8'h01, d); check("R7 sw lock silent", d, 8'h00);
        rd(8'h02, d); check("R7 status follows sw lock", d & 8'h20, 8'h20);
        lock_level = 0; lock_sw = 1; @(negedge clk); lock_sw = 0;
        rd(8'h01, d); check("R7 sw unlock silent", d, 8'h00);

        // R8 R9: every GPI pin in both routings.
        for (int p = 0; p < NG; p++) begin
            gpi_ev[p] = 1; @(negedge clk); gpi_ev = '0;
            for (int r = 0; r < NREG; r++) begin
                rd(8'(3 + r), d);
                check("R8 pin register", d, (r == p / 8) ? 8'(1 << (p % 8)) : 8'h00);
            end
            rd(8'h01, d); check("R8 summary set", d, 8'h02);
            wr(8'h01, 8'h02);
            rd(8'h01, d); check("R9 summary held", d, 8'h02);
            wr(8'(3 + p / 8), 8'(1 << (p % 8)));
            rd(8'(3 + p / 8), d); check("R8 pin cleared", d, 8'h00);
            wr(8'h01, 8'h02);
            rd(8'h01, d); check("R9 summary cleared", d, 8'h00);
            gpi_fifo[p] = 1; gpi_ev[p] = 1; @(negedge clk); gpi_ev = '0; gpi_fifo = '0;
            rd(8'h01, d); check("R8 fifo route sets event only", d, 8'h01);
            rd(8'(3 + p / 8), d); check("R8 fifo route no pin flag", d, 8'h00);
            wr(8'h01, 8'h01);
        end

        // R11: status word over all counts and logic output patterns.
        for (int i = 0; i < 32; i++) begin
            fifo_count = 5'(i); logic1_out = i[0]; logic2_out = i[1];
            rd(8'h02, d); check("R11 status", d, {i[1], i[0], 1'b0, 5'(i)});
        end

        // R13: unmapped reads and writes.
        pulse(3);
        for (int a = 3 + NREG; a < 256; a++) begin
            wr(8'(a), 8'hFF);
            rd(8'(a), d); check("R13 unmapped reads zero", d, 8'h00);
        end
        rd(8'h01, d); check("R13 writes left flags", d, 8'h04);

        // R14: read data holds without a strobe.
        reg_addr = 8'h00; repeat (3) @(negedge clk);
        check("R14 read data held", reg_rd_data, 8'h04);
        wr(8'h01, 8'h04);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule